// File: doc/BRIEF.md
# Windowed Bit-Field Unpacker

This block turns a packed bit stream into a sequence of separate small values. Software-side logic loads one to four 64-bit words at once into a 256-bit shift register. The stream is read from the least significant bit of the lowest word upward. A stream of descriptors then drives the unit. Each descriptor names how many bits to discard and how many bits to take as the next field. Every field is zero-extended to 64 bits and handed out on its own numbered destination slot.

Extraction only ever looks at the lowest 64 bits of the register. A read pointer marks the next unread bit inside that window. A field whose end would pass the top of the window is not reached for through a wider multiplexer. Instead the descriptor is held off, and the register drops one fully consumed 16-bit chunk per cycle until the field fits. When too few loaded bits remain, the descriptor waits until more words arrive. A flush discards everything held.

Top module: `bitfield_unpacker`

## Requirements
- R1: After reset, `field_valid` is 0, `desc_ready` is 0 for any descriptor, and `load_ready` is 1 for a one-word load.
- R2: A load accepted in one cycle appends `load_n` words (1 to 4). Word 0 (`load_data[63:0]`) comes first and its bit 0 is the earliest stream bit. `load_ready` is 0 when the held 16-bit chunks plus 4 per new word would exceed 16 chunks (256 bits).
- R3: An accepted descriptor discards `desc_skip` stream bits and then takes the next `desc_width` bits as one field, lowest bit first. The field is presented on `field_data` in the cycle after acceptance.
- R4: Widths from 4 to 15 and skips from 0 to 31 are supported. `field_data` bits above the field width are 0.
- R5: A descriptor is taken only if the read pointer plus skip plus width stays within the 64-bit window. Otherwise `desc_ready` is 0 and the window advances by 16 bits per cycle. From pointer 60, a width-10 field waits exactly one cycle. From pointer 60, a skip-31 width-15 field waits three cycles.
- R6: While the held unread bits are fewer than the descriptor needs, `desc_ready` stays 0. It resumes after a load supplies the bits, and the field then spans the old and new data correctly.
- R7: `field_slot` numbers the fields 0, 1, 2, … in acceptance order, wrapping after 15. Numbering restarts at 0 after reset or flush.
- R8: While `flush` is 1, `desc_ready` and `load_ready` are 0. In the next cycle `field_valid` is 0 and all held data is dropped. The first field after a reload is taken from the first bit of the new data, on slot 0.
- R9: `field_valid` is 1 only in the cycle following an accepted descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous clear of all held data and slot numbering |
| load_valid | input | 1 | Load request |
| load_n | input | 3 | Number of words in this load (1 to 4) |
| load_data | input | 256 | Words to load, word 0 in the low 64 bits |
| load_ready | output | 1 | Load of `load_n` words fits this cycle |
| desc_valid | input | 1 | Descriptor present |
| desc_skip | input | 5 | Bits to discard before the field |
| desc_width | input | 4 | Field width in bits (4 to 15) |
| desc_ready | output | 1 | Presented descriptor is taken this cycle |
| field_valid | output | 1 | Field output valid |
| field_data | output | 64 | Zero-extended field |
| field_slot | output | 4 | Destination slot number of the field |

## Verification
The unpacking is exercised with descriptor runs that stay inside one freshly loaded word. These runs include the extreme widths and skips and a field ending exactly on bit 64. They separate bit ordering and masking errors from window handling. Chained runs then drive the pointer to 60 and ask for fields that overrun the window. The exact wait counts there expose a wrong chunk step or a wrong fit test. A starved run with one word loaded, followed by a late load, shows whether an unread tail joins new data at the right bit. A four-word load consumed by sixteen 16-bit steps checks capacity, every chunk boundary and slot wrap. A flush in mid-stream shows whether stale bits or slot numbers survive.

// File: rtl/bitfield_unpacker.sv
module bitfield_unpacker #(
  parameter int WORD_W  = 64,
  parameter int NWORDS  = 4,
  parameter int CHUNK_W = 16,
  parameter int SKIP_W  = 5,
  parameter int WID_W   = 4,
  parameter int SLOT_W  = 4
)(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush,
  input  logic                        load_valid,
  input  logic [$clog2(NWORDS+1)-1:0] load_n,
  input  logic [WORD_W*NWORDS-1:0]    load_data,
  output logic                        load_ready,
  input  logic                        desc_valid,
  input  logic [SKIP_W-1:0]           desc_skip,
  input  logic [WID_W-1:0]            desc_width,
  output logic                        desc_ready,
  output logic                        field_valid,
  output logic [WORD_W-1:0]           field_data,
  output logic [SLOT_W-1:0]           field_slot
);
  localparam int SR_W   = WORD_W * NWORDS;
  localparam int NCHUNK = SR_W / CHUNK_W;
  localparam int CPW    = WORD_W / CHUNK_W;
  localparam int PTR_W  = $clog2(WORD_W) + 1;
  localparam int CNT_W  = $clog2(NCHUNK + 1);
  localparam int SUM_W  = 16;

  logic [SR_W-1:0]   sr, sr_shift, sr_load, lmask;
  logic [PTR_W-1:0]  ptr;
  logic [CNT_W-1:0]  nchunk, n_after;
  logic [SLOT_W-1:0] slot_ctr;
  logic [SUM_W-1:0]  fstart, fend, avail, need;
  logic [WORD_W-1:0] field_bits;
  logic              fit, fire, do_shift, take;

  assign fstart = SUM_W'(ptr) + SUM_W'(desc_skip);
  assign fend   = fstart + SUM_W'(desc_width);
  assign avail  = SUM_W'(nchunk) * SUM_W'(CHUNK_W);
  assign fit    = (fend <= SUM_W'(WORD_W)) && (fend <= avail);

  assign desc_ready = !flush && fit;
  assign fire       = desc_valid && desc_ready;
  assign do_shift   = !flush && !fire && (SUM_W'(ptr) >= SUM_W'(CHUNK_W));

  assign need       = SUM_W'(load_n) * SUM_W'(CPW);
  assign load_ready = !flush && (SUM_W'(nchunk) + need <= SUM_W'(NCHUNK));
  assign take       = load_valid && load_ready;

  always_comb begin
    lmask = '0;
    for (int i = 0; i < NWORDS; i++)
      if (i < int'(load_n)) lmask[i*WORD_W +: WORD_W] = '1;
  end

  assign n_after    = nchunk - CNT_W'(do_shift);
  assign sr_shift   = do_shift ? (sr >> CHUNK_W) : sr;
  assign sr_load    = (load_data & lmask) << (SUM_W'(n_after) * SUM_W'(CHUNK_W));
  assign field_bits = (sr[WORD_W-1:0] >> fstart) & ~({WORD_W{1'b1}} << desc_width);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0; ptr <= '0; nchunk <= '0; slot_ctr <= '0;
      field_valid <= 1'b0; field_data <= '0; field_slot <= '0;
    end else if (flush) begin
      sr <= '0; ptr <= '0; nchunk <= '0; slot_ctr <= '0;
      field_valid <= 1'b0;
    end else begin
      sr          <= take ? (sr_shift | sr_load) : sr_shift;
      nchunk      <= take ? n_after + CNT_W'(need) : n_after;
      field_valid <= fire;
      if (fire) begin
        ptr        <= PTR_W'(fend);
        field_data <= field_bits;
        field_slot <= slot_ctr;
        slot_ctr   <= slot_ctr + 1'b1;
      end else if (do_shift) begin
        ptr <= ptr - PTR_W'(CHUNK_W);
      end
    end
  end
endmodule

// File: rtl/bitfield_unpacker_chk.sv
module bitfield_unpacker_chk #(
  parameter int WORD_W = 64,
  parameter int SLOT_W = 4
)(
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              load_ready,
  input logic              desc_valid,
  input logic              desc_ready,
  input logic              field_valid,
  input logic [WORD_W-1:0] field_data,
  input logic [SLOT_W-1:0] field_slot
);
  p_accept_shows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && desc_ready) |=> field_valid);

  p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(desc_valid && desc_ready) |=> !field_valid);

  p_zero_ext_r4: assert property (@(posedge clk) disable iff (!rst_n)
    field_valid |-> ((field_data >> 15) == '0));

  p_slot_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (field_valid && $past(field_valid)) |-> (field_slot == $past(field_slot) + 1'b1));

  p_flush_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!desc_ready && !load_ready));

  p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !field_valid);
endmodule

bind bitfield_unpacker bitfield_unpacker_chk #(.WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .load_ready(load_ready),
  .desc_valid(desc_valid), .desc_ready(desc_ready), .field_valid(field_valid),
  .field_data(field_data), .field_slot(field_slot)
);

// File: tb/bitfield_unpacker_tb_top.sv
module bitfield_unpacker_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic load_valid = 1'b0;
  logic [2:0] load_n = 3'd1;
  logic [255:0] load_data = '0;
  logic desc_valid = 1'b0;
  logic [4:0] desc_skip = '0;
  logic [3:0] desc_width = 4'd4;
  logic load_ready, desc_ready, field_valid;
  logic [63:0] field_data;
  logic [3:0] field_slot;

  int checks = 0, failures = 0;
  logic [2047:0] refs = '0;
  int rd = 0, wr = 0, eslot = 0;

  always #4 clk = ~clk;

  bitfield_unpacker dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .load_valid(load_valid), .load_n(load_n),
    .load_data(load_data), .load_ready(load_ready), .desc_valid(desc_valid),
    .desc_skip(desc_skip), .desc_width(desc_width), .desc_ready(desc_ready),
    .field_valid(field_valid), .field_data(field_data), .field_slot(field_slot)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ref_clear();
    refs = '0; rd = 0; wr = 0; eslot = 0;
  endtask

  task automatic flush_pulse();
    flush = 1'b1;
    @(posedge clk); @(negedge clk);
    flush = 1'b0;
    ref_clear();
  endtask

  task automatic load_words(input int n, input logic [255:0] data);
    load_valid = 1'b1; load_n = 3'(n); load_data = data;
    #1;
    chk(load_ready == 1'b1, "R2 load accepted", 64'(load_ready), 64'd1);
    @(posedge clk); @(negedge clk);
    load_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      refs[wr +: 64] = data[i*64 +: 64];
      wr += 64;
    end
  endtask

  task automatic send_desc(input int skip, input int w, input int exp_wait, input string req);
    int waits = 0;
    logic [63:0] exp;
    desc_valid = 1'b1; desc_skip = 5'(skip); desc_width = 4'(w);
    #1;
    while (!desc_ready && waits < 200) begin
      @(negedge clk); #1; waits++;
    end
    exp = 64'(refs >> (rd + skip)) & ((64'd1 << w) - 64'd1);
    @(posedge clk); @(negedge clk);
    desc_valid = 1'b0;
    chk(field_valid == 1'b1, {req, " valid"}, 64'(field_valid), 64'd1);
    chk(field_data == exp, {req, " data"}, field_data, exp);
    chk(field_slot == 4'(eslot), "R7 slot", 64'(field_slot), 64'(eslot));
    if (exp_wait >= 0) chk(waits == exp_wait, "R5 wait cycles", 64'(waits), 64'(exp_wait));
    rd += skip + w;
    eslot = (eslot + 1) % 16;
  endtask

  task automatic t_reset();
    desc_valid = 1'b1; desc_skip = '0; desc_width = 4'd4; load_n = 3'd1;
    #1;
    chk(field_valid == 1'b0, "R1 field_valid", 64'(field_valid), 64'd0);
    chk(desc_ready == 1'b0, "R1 desc_ready", 64'(desc_ready), 64'd0);
    chk(load_ready == 1'b1, "R1 load_ready", 64'(load_ready), 64'd1);
    desc_valid = 1'b0;
  endtask

  task automatic t_basic();
    flush_pulse();
    load_words(1, 256'h0000_0000_0000_0000_0000_0000_0000_0000_0000_0000_0000_0000_FEDC_BA98_7654_3210);
    send_desc(0, 4, 0, "R3 first nibble");
    send_desc(31, 4, 0, "R4 max skip min width");
    send_desc(0, 15, 0, "R4 max width");
    send_desc(2, 8, 0, "R3 ends on bit 64");
    @(negedge clk);
    chk(field_valid == 1'b0, "R9 idle no field", 64'(field_valid), 64'd0);
  endtask

  task automatic t_window();
    flush_pulse();
    load_words(2, {128'd0, 64'h0F1E_2D3C_4B5A_6978, 64'h8796_A5B4_C3D2_E1F0});
    send_desc(31, 15, 0, "R3 win a");
    send_desc(0, 14, 0, "R3 win b");
    send_desc(0, 10, 1, "R5 one wait");
    send_desc(31, 15, 3, "R5 three waits");
  endtask

  task automatic t_starve();
    flush_pulse();
    load_words(1, {192'd0, 64'hA5A5_5A5A_C3C3_3C3C});
    send_desc(31, 15, 0, "R3 starve a");
    send_desc(0, 14, 0, "R3 starve b");
    desc_valid = 1'b1; desc_skip = '0; desc_width = 4'd10;
    for (int i = 0; i < 5; i++) begin
      #1;
      chk(desc_ready == 1'b0, "R6 starved", 64'(desc_ready), 64'd0);
      @(negedge clk);
    end
    load_words(1, {192'd0, 64'h1357_9BDF_2468_ACE0});
    send_desc(0, 10, -1, "R6 resumes across words");
    send_desc(5, 12, -1, "R6 new data");
  endtask

  task automatic t_full();
    logic [255:0] d;
    flush_pulse();
    for (int i = 0; i < 8; i++) d[i*32 +: 32] = 32'h9E37_79B9 * (i + 3);
    load_words(4, d);
    load_n = 3'd1;
    #1;
    chk(load_ready == 1'b0, "R2 full refuses", 64'(load_ready), 64'd0);
    @(negedge clk);
    for (int i = 0; i < 16; i++) send_desc(1, 15, -1, "R2 four word batch");
    load_words(1, {192'd0, 64'hDEAD_BEEF_0BAD_F00D});
    send_desc(0, 8, -1, "R7 slot wrap");
  endtask

  task automatic t_flush();
    flush_pulse();
    load_words(1, {192'd0, 64'h1111_2222_3333_4444});
    send_desc(0, 12, -1, "R3 pre flush");
    desc_valid = 1'b1; desc_skip = '0; desc_width = 4'd4;
    flush = 1'b1;
    #1;
    chk(desc_ready == 1'b0, "R8 desc blocked", 64'(desc_ready), 64'd0);
    chk(load_ready == 1'b0, "R8 load blocked", 64'(load_ready), 64'd0);
    @(posedge clk); @(negedge clk);
    flush = 1'b0;
    ref_clear();
    #1;
    chk(field_valid == 1'b0, "R8 no field", 64'(field_valid), 64'd0);
    chk(desc_ready == 1'b0, "R8 data dropped", 64'(desc_ready), 64'd0);
    @(negedge clk);
    desc_valid = 1'b0;
    load_words(1, {192'd0, 64'h0000_0000_0000_00C7});
    send_desc(0, 8, -1, "R8 restart at bit 0");
  endtask

  initial begin
    #1;
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_window();
    t_starve();
    t_full();
    t_flush();
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule